// File: doc/BRIEF.md
# Power-Good Cascade Sequencer

This block brings up three platform power-good outputs one after another once the aggregate system power-good input is high. First it raises a core-rail good, then a chipset power-ok, then a system power-ok. A timed pause is inserted before each step. The pauses are measured in rising edges of a 1 ms timebase tick, so the block runs from any fast clock.

The chipset power-ok step waits for a voltage-regulator ready input. If that input does not arrive before a timeout, the bring-up is abandoned. After the long pause that comes before the system power-ok, the aggregate power-good is checked once more. If it is lost at any time, all three outputs collapse together.

A one-clock fault pulse marks an abandoned bring-up. After an abort, the sequencer stays quiet until the aggregate power-good has gone low and then high again.

Top module: `pgood_cascade`

## Requirements
- R1: While synchronous active-high reset is applied, coreGood, chipOk, sysOk and faultPulse are all 0 on the following clock.
- R2: Whenever sysPgood is sampled low, all three outputs are 0 on the next clock, whatever stage the cascade was in.
- R3: After sysPgood is seen high, coreGood rises only once CORE_DLY (default 2) rising edges of msTick have been counted; after CORE_DLY-1 edges it is still 0.
- R4: Only rising edges of msTick are counted. A tick that is held high for several clocks counts once.
- R5: Once coreGood is high, chipOk rises only after vrReady has been seen high and then CHIP_DLY (default 2) further msTick edges have been counted.
- R6: If vrReady stays low for VR_TIMEOUT (default 50) msTick edges after coreGood rises, all outputs drop and faultPulse is high for exactly one clock.
- R7: sysOk rises SYS_DLY (default 45) msTick edges after chipOk rises, provided sysPgood is still high.
- R8: Loss of sysPgood during the pause before sysOk drops all outputs and pulses faultPulse for one clock. Loss of sysPgood in any other stage gives no fault pulse.
- R9: After an abort, the outputs stay 0 while sysPgood remains high. A fresh cascade starts only after sysPgood has been low and then high again.
- R10: chipOk is never 1 unless coreGood is 1, and sysOk is never 1 unless chipOk is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| msTick | input | 1 | 1 ms timebase; each rising edge is one count |
| sysPgood | input | 1 | Aggregate system power-good |
| vrReady | input | 1 | Voltage-regulator ready |
| coreGood | output | 1 | Core-rail good, first in the cascade |
| chipOk | output | 1 | Chipset power-ok, second in the cascade |
| sysOk | output | 1 | System power-ok, last in the cascade |
| faultPulse | output | 1 | One-clock pulse on an abandoned bring-up |

## Verification
A stage register stuck in the wrong state shows up within one clock as an output pattern that breaks the cascade order, or as an output that stays high after sysPgood has gone low. A delay counter that is cleared wrongly, or that counts levels instead of edges, moves the rising edge of an output by one or more ticks. The bench therefore samples each output one tick before and one tick after its expected rise. A bad abort path shows either as a fault pulse wider than one clock, or as a cascade that restarts without sysPgood first going low.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORE_WAIT,
    ST_VR_WAIT,
    ST_CHIP_WAIT,
    ST_SYS_WAIT,
    ST_ON,
    ST_ABORT
  } seqState_t;

  typedef struct packed {
    logic clr;
  } timerCtl_t;

endpackage

// File: rtl/pgc_timer.sv
module pgc_timer #(
  parameter int CW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 msTick,
  input  pgc_pkg::timerCtl_t   ctl,
  output logic [CW-1:0]        cnt
);

  logic tickQ;
  logic tickRise;

  assign tickRise = msTick & ~tickQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      tickQ <= 1'b0;
      cnt   <= '0;
    end else begin
      tickQ <= msTick;
      if (ctl.clr)
        cnt <= '0;
      else if (tickRise && (cnt != {CW{1'b1}}))
        cnt <= cnt + 1'b1;
    end
  end

  // R3: a stage entry restarts its delay from zero
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.clr |=> (cnt == '0));

  // R4: the count moves by at most one per clock and only on a new tick edge
  p_edge_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl.clr && !(msTick && !tickQ)) |=> $stable(cnt));

endmodule

// File: rtl/pgc_ctrl.sv
module pgc_ctrl #(
  parameter int CW         = 6,
  parameter int CORE_DLY   = 2,
  parameter int VR_TIMEOUT = 50,
  parameter int CHIP_DLY   = 2,
  parameter int SYS_DLY    = 45
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sysPgood,
  input  logic                vrReady,
  input  logic [CW-1:0]       cnt,
  output pgc_pkg::timerCtl_t  ctl,
  output logic                coreGood,
  output logic                chipOk,
  output logic                sysOk,
  output logic                faultPulse
);
  import pgc_pkg::*;

  localparam logic [CW-1:0] kCore = CW'(CORE_DLY);
  localparam logic [CW-1:0] kVr   = CW'(VR_TIMEOUT);
  localparam logic [CW-1:0] kChip = CW'(CHIP_DLY);
  localparam logic [CW-1:0] kSys  = CW'(SYS_DLY);

  seqState_t st, nxt;
  logic      faultNxt;

  always_comb begin
    nxt      = st;
    faultNxt = 1'b0;
    case (st)
      ST_IDLE:      if (sysPgood) nxt = ST_CORE_WAIT;
      ST_CORE_WAIT: if (!sysPgood) nxt = ST_IDLE;
                    else if (cnt == kCore) nxt = ST_VR_WAIT;
      ST_VR_WAIT:   if (!sysPgood) nxt = ST_IDLE;
                    else if (vrReady) nxt = ST_CHIP_WAIT;
                    else if (cnt == kVr) begin
                      nxt      = ST_ABORT;
                      faultNxt = 1'b1;
                    end
      ST_CHIP_WAIT: if (!sysPgood) nxt = ST_IDLE;
                    else if (cnt == kChip) nxt = ST_SYS_WAIT;
      ST_SYS_WAIT:  if (!sysPgood) begin
                      nxt      = ST_IDLE;
                      faultNxt = 1'b1;
                    end else if (cnt == kSys) nxt = ST_ON;
      ST_ON:        if (!sysPgood) nxt = ST_IDLE;
      ST_ABORT:     if (!sysPgood) nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
    ctl.clr = (nxt != st);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      coreGood   <= 1'b0;
      chipOk     <= 1'b0;
      sysOk      <= 1'b0;
      faultPulse <= 1'b0;
    end else begin
      st         <= nxt;
      coreGood   <= (nxt == ST_VR_WAIT) || (nxt == ST_CHIP_WAIT) ||
                    (nxt == ST_SYS_WAIT) || (nxt == ST_ON);
      chipOk     <= (nxt == ST_SYS_WAIT) || (nxt == ST_ON);
      sysOk      <= (nxt == ST_ON);
      faultPulse <= faultNxt;
    end
  end

  // R1: reset clears every output
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!coreGood && !chipOk && !sysOk && !faultPulse));

  // R2: power-good loss collapses the cascade on the next clock
  p_collapse_r2: assert property (@(posedge clk) disable iff (rst)
    !sysPgood |=> (!coreGood && !chipOk && !sysOk));

  // R6: the fault indication never lasts more than one clock
  p_fault_single_r6: assert property (@(posedge clk) disable iff (rst)
    faultPulse |=> !faultPulse);

  // R9: once aborted, nothing rises while power-good stays high
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ABORT && sysPgood) |=> !coreGood);

  // R10: cascade order is preserved
  p_order_r10: assert property (@(posedge clk) disable iff (rst)
    (!chipOk || coreGood) && (!sysOk || chipOk));

endmodule

// File: rtl/pgood_cascade.sv
module pgood_cascade #(
  parameter int CORE_DLY   = 2,
  parameter int VR_TIMEOUT = 50,
  parameter int CHIP_DLY   = 2,
  parameter int SYS_DLY    = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic msTick,
  input  logic sysPgood,
  input  logic vrReady,
  output logic coreGood,
  output logic chipOk,
  output logic sysOk,
  output logic faultPulse
);

  localparam int MAX_A = (CORE_DLY > CHIP_DLY) ? CORE_DLY : CHIP_DLY;
  localparam int MAX_B = (VR_TIMEOUT > SYS_DLY) ? VR_TIMEOUT : SYS_DLY;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_D + 2);

  pgc_pkg::timerCtl_t tmrCtl;
  logic [CW-1:0]      tmrCnt;

  pgc_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .msTick (msTick),
    .ctl    (tmrCtl),
    .cnt    (tmrCnt)
  );

  pgc_ctrl #(
    .CW         (CW),
    .CORE_DLY   (CORE_DLY),
    .VR_TIMEOUT (VR_TIMEOUT),
    .CHIP_DLY   (CHIP_DLY),
    .SYS_DLY    (SYS_DLY)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sysPgood   (sysPgood),
    .vrReady    (vrReady),
    .cnt        (tmrCnt),
    .ctl        (tmrCtl),
    .coreGood   (coreGood),
    .chipOk     (chipOk),
    .sysOk      (sysOk),
    .faultPulse (faultPulse)
  );

endmodule

// File: tb/test_pgood_cascade.sv
`timescale 1ns/1ps
module test_pgood_cascade;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msTick = 1'b0;
  logic sysPgood = 1'b0;
  logic vrReady = 1'b0;
  logic coreGood, chipOk, sysOk, faultPulse;

  int checks = 0;
  int failures = 0;
  int faultCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pgood_cascade i_pgood_cascade (
    .clk(clk), .rst(rst), .msTick(msTick), .sysPgood(sysPgood),
    .vrReady(vrReady), .coreGood(coreGood), .chipOk(chipOk),
    .sysOk(sysOk), .faultPulse(faultPulse)
  );

  always @(posedge clk) if (faultPulse) faultCnt <= faultCnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {29'd0, coreGood, chipOk, sysOk};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
      idle(4);
    end
  endtask

  task automatic powerDown();
    @(negedge clk) sysPgood = 1'b0;
    vrReady = 1'b0;
    idle(3);
  endtask

  task automatic testReset();
    idle(3);
    @(negedge clk) rst = 1'b0;
    chk("R1 outputs after reset", outs(), 0);
    chk("R1 fault after reset", int'(faultPulse), 0);
  endtask

  task automatic testFullCascade();
    @(negedge clk) sysPgood = 1'b1;
    idle(2);
    tick(1);
    chk("R3 core low one tick early", int'(coreGood), 0);
    tick(1);
    chk("R3 core high after delay", outs(), 3'b100);
    tick(3);
    @(negedge clk) vrReady = 1'b1;
    idle(2);
    tick(1);
    chk("R5 chip low one tick early", int'(chipOk), 0);
    tick(1);
    chk("R5 chip high after delay", outs(), 3'b110);
    tick(44);
    chk("R7 sys low one tick early", int'(sysOk), 0);
    tick(1);
    chk("R7 sys high after delay", outs(), 3'b111);
    chk("R10 full order", outs(), 3'b111);
    @(negedge clk) sysPgood = 1'b0;
    @(negedge clk);
    chk("R2 collapse from on", outs(), 0);
    vrReady = 1'b0;
    idle(2);
  endtask

  task automatic testHeldTick();
    @(negedge clk) sysPgood = 1'b1;
    idle(2);
    @(negedge clk) msTick = 1'b1;
    idle(8);
    @(negedge clk) msTick = 1'b0;
    idle(4);
    chk("R4 held tick counts once", int'(coreGood), 0);
    tick(1);
    chk("R4 next edge completes delay", int'(coreGood), 1);
    powerDown();
  endtask

  task automatic testTimeout();
    int base;
    base = faultCnt;
    @(negedge clk) sysPgood = 1'b1;
    idle(2);
    tick(2);
    chk("R6 core up before timeout", int'(coreGood), 1);
    tick(49);
    chk("R6 still waiting one tick early", outs(), 3'b100);
    chk("R6 no fault yet", faultCnt - base, 0);
    tick(1);
    chk("R6 outputs dropped on timeout", outs(), 0);
    chk("R6 single fault cycle", faultCnt - base, 1);
    tick(5);
    chk("R9 no restart while pgood high", outs(), 0);
    @(negedge clk) vrReady = 1'b1;
    tick(3);
    chk("R9 ready ignored after abort", outs(), 0);
    powerDown();
    @(negedge clk) sysPgood = 1'b1;
    idle(2);
    tick(2);
    chk("R9 restart after low then high", int'(coreGood), 1);
    powerDown();
  endtask

  task automatic testLossInSysWait();
    int base;
    @(negedge clk) sysPgood = 1'b1;
    vrReady = 1'b1;
    idle(2);
    tick(2);
    idle(2);
    tick(2);
    chk("R10 chip with core", outs(), 3'b110);
    tick(10);
    base = faultCnt;
    @(negedge clk) sysPgood = 1'b0;
    idle(3);
    chk("R8 collapse in final wait", outs(), 0);
    chk("R8 fault pulse on loss", faultCnt - base, 1);
    vrReady = 1'b0;
    idle(2);
  endtask

  task automatic testLossInVrWait();
    int base;
    @(negedge clk) sysPgood = 1'b1;
    idle(2);
    tick(2);
    tick(5);
    base = faultCnt;
    @(negedge clk) sysPgood = 1'b0;
    @(negedge clk);
    chk("R2 collapse while waiting on regulator", outs(), 0);
    idle(2);
    chk("R8 no fault outside final wait", faultCnt - base, 0);
  endtask

  initial begin
    testReset();
    testFullCascade();
    testHeldTick();
    testTimeout();
    testLossInSysWait();
    testLossInVrWait();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule